// File: doc/BRIEF.md
# Four-Way Intersection Light Sequencer

This block drives the signal heads of a crossing between an east-west road and a north-south road. Each road has one head with red, yellow and green lamps. The heads cover the straight-through movement and the one turn that crosses oncoming traffic. The turns that cross nothing run without a signal, so the block has no output for them.

The block runs a fixed loop of six phases. Green for east-west is followed by yellow, then by a long all-red clearance. North-south then gets the same green, yellow and clearance, and the loop repeats.

All timing counts pulses on a one-cycle tick input that comes from an external prescaler. Cycles without a tick freeze the sequencer. A single down-counter measures the current phase. Its value is brought out together with the phase number, so the remaining dwell can be seen at any time.

Top module: `xing_light_seq`

## Requirements
- R1: With `rst` high at a rising clock edge, the next cycle shows phase 0, `remain` equal to GREEN_TICKS (default 120), `ew_lamp` green and `ns_lamp` red.
- R2: Each lamp vector is {green, yellow, red}, so red is 3'b001, yellow is 3'b010 and green is 3'b100. In phases 0 to 5, east-west shows green, yellow, red, red, red, red. In the same phases, north-south shows red, red, red, green, yellow, red.
- R3: The phases follow the order 0,1,2,3,4,5. After phase 5 the block returns to phase 0.
- R4: Measured in tick pulses, phases 0 and 3 last GREEN_TICKS (120), phases 1 and 4 last AMBER_TICKS (5), and phases 2 and 5 last CLEAR_TICKS (60).
- R5: On each tick, `remain` drops by one while it is above 1. The tick that finds `remain` at 1 moves the block to the next phase and loads that phase's full length on the same edge.
- R6: A cycle with `tick` low leaves `phase` and `remain` unchanged.
- R7: `ew_lamp` and `ns_lamp` are each one-hot in every cycle.
- R8: The two roads are never both non-red in the same cycle.
- R9: A reset in the middle of a phase gives the R1 state on the next cycle, even when `tick` is high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timebase pulse |
| ew_lamp | output | 3 | East-west head, {green, yellow, red} |
| ns_lamp | output | 3 | North-south head, {green, yellow, red} |
| phase | output | 3 | Current phase, 0 to 5 |
| remain | output | TW | Ticks left in the current phase, from the phase length down to 1 |

## Verification
A corrupted phase register shows up on the very next cycle, because both lamp vectors and `phase` decode from it with no extra register in the path. A corrupted timer is quieter. A wrong reload value or a wrong decrement shows on `remain` on the next tick. The same fault changes when the lamps change only at the end of the affected phase, which can be up to 120 ticks later. For that reason the bench compares `remain` after every edge, and it also measures the length of each phase from the observed lamp changes.

// File: rtl/xing_light_seq.sv
module xing_light_seq #(
  parameter int GREEN_TICKS = 120,
  parameter int AMBER_TICKS = 5,
  parameter int CLEAR_TICKS = 60,
  localparam int MAXT = (GREEN_TICKS > AMBER_TICKS ? (GREEN_TICKS > CLEAR_TICKS ? GREEN_TICKS : CLEAR_TICKS)
                                                   : (AMBER_TICKS > CLEAR_TICKS ? AMBER_TICKS : CLEAR_TICKS)),
  localparam int TW = $clog2(MAXT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [2:0]    ew_lamp,
  output logic [2:0]    ns_lamp,
  output logic [2:0]    phase,
  output logic [TW-1:0] remain
);

  localparam logic [2:0] RED = 3'b001;
  localparam logic [2:0] YEL = 3'b010;
  localparam logic [2:0] GRN = 3'b100;
  localparam logic [2:0] LAST = 3'd5;

  function automatic logic [TW-1:0] len_of(input logic [2:0] p);
    case (p)
      3'd0, 3'd3: len_of = TW'(GREEN_TICKS);
      3'd1, 3'd4: len_of = TW'(AMBER_TICKS);
      default:    len_of = TW'(CLEAR_TICKS);
    endcase
  endfunction

  logic [2:0] nxt_phase;
  logic       expire;

  assign nxt_phase = (phase == LAST) ? 3'd0 : phase + 3'd1;
  assign expire    = tick && (remain == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 3'd0;
      remain <= TW'(GREEN_TICKS);
    end else if (expire) begin
      phase  <= nxt_phase;
      remain <= len_of(nxt_phase);
    end else if (tick) begin
      remain <= remain - TW'(1);
    end
  end

  always_comb begin
    ew_lamp = RED;
    ns_lamp = RED;
    case (phase)
      3'd0: ew_lamp = GRN;
      3'd1: ew_lamp = YEL;
      3'd3: ns_lamp = GRN;
      3'd4: ns_lamp = YEL;
      default: ;
    endcase
  end

  assert_lamp_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot(ew_lamp) && $onehot(ns_lamp));

  assert_no_conflict_R8: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == RED) || (ns_lamp == RED));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase) && $stable(remain));

  assert_countdown_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && remain > TW'(1)) |=> (remain == $past(remain) - TW'(1)) && $stable(phase));

  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && remain == TW'(1)) |=> phase != $past(phase));

  assert_timer_live_R4: assert property (@(posedge clk) disable iff (rst)
    remain != '0 && phase <= LAST);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> phase == 3'd0 && remain == TW'(GREEN_TICKS));

endmodule

// File: tb/xing_light_seq_tb.sv
module xing_light_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] RED = 3'b001, YEL = 3'b010, GRN = 3'b100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [2:0] ew_lamp, ns_lamp, phase;
  logic [6:0] remain;

  xing_light_seq dut_i (
    .clk(clk), .rst(rst), .tick(tick),
    .ew_lamp(ew_lamp), .ns_lamp(ns_lamp), .phase(phase), .remain(remain)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0] ph;
    logic [6:0] rem;
    logic [2:0] ew;
    logic [2:0] ns;
    logic       tk;
    logic       rs;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [2:0] m_ph;
  logic [6:0] m_rem;

  function automatic int len_of(input logic [2:0] p);
    case (p)
      3'd0, 3'd3: return 120;
      3'd1, 3'd4: return 5;
      default:    return 60;
    endcase
  endfunction

  function automatic logic [2:0] ew_of(input logic [2:0] p);
    return p == 0 ? GRN : (p == 1 ? YEL : RED);
  endfunction

  function automatic logic [2:0] ns_of(input logic [2:0] p);
    return p == 3 ? GRN : (p == 4 ? YEL : RED);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic r, input logic t);
    item_t it;
    @(negedge clk);
    rst = r;
    tick = t;
    if (r) begin
      m_ph = 0; m_rem = 120;
    end else if (t) begin
      if (m_rem == 1) begin
        m_ph = (m_ph == 5) ? 3'd0 : m_ph + 3'd1;
        m_rem = 7'(len_of(m_ph));
      end else m_rem = m_rem - 7'd1;
    end
    it.ph = m_ph; it.rem = m_rem; it.ew = ew_of(m_ph); it.ns = ns_of(m_ph);
    it.tk = t; it.rs = r;
    exp_q.push_back(it);
  endtask

  int run_ticks = 0;
  logic [2:0] prev_ph = 3'd0;
  bit first_rst = 1;

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      if (e.rs) begin
        if (first_rst) begin
          chk("R1 phase", phase, 0);
          chk("R1 remain", remain, 120);
          chk("R1 ew_lamp", ew_lamp, GRN);
          chk("R1 ns_lamp", ns_lamp, RED);
        end else begin
          chk("R9 phase", phase, 0);
          chk("R9 remain", remain, 120);
        end
        run_ticks = 0;
        prev_ph = 3'd0;
      end else begin
        first_rst = 0;
        if (e.tk) begin
          chk("R3 phase", phase, e.ph);
          chk("R5 remain", remain, e.rem);
          if (phase != prev_ph) begin
            chk("R4 duration", run_ticks + 1, len_of(prev_ph));
            run_ticks = 0;
          end else run_ticks++;
          prev_ph = phase;
        end else begin
          chk("R6 phase", phase, e.ph);
          chk("R6 remain", remain, e.rem);
        end
        chk("R2 ew_lamp", ew_lamp, e.ew);
        chk("R2 ns_lamp", ns_lamp, e.ns);
      end
      chk("R7 onehot", int'($onehot(ew_lamp) && $onehot(ns_lamp)), 1);
      chk("R8 conflict", int'(ew_lamp == RED || ns_lamp == RED), 1);
    end
  end

  initial begin
    m_ph = 0; m_rem = 120;
    drive(1, 0);
    drive(1, 1);
    for (int i = 0; i < 20; i++) drive(0, 0);
    for (int i = 0; i < 2 * 370 + 10; i++) drive(0, 1);
    for (int i = 0; i < 3 * 370; i++) drive(0, (i % 3) == 0);
    while (m_ph != 3 || m_rem != 50) drive(0, 1);
    drive(1, 1);
    for (int i = 0; i < 400; i++) drive(0, 1);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule